// File: doc/BRIEF.md
# MOESI Coherence State Controller

This block keeps the coherence state of every line of one private, direct-mapped cache in a small shared-memory multiprocessor. Each line is in one of five states: Modified, Owned, Exclusive, Shared or Invalid. Each cycle the block accepts at most one local processor event (read, write, evict) and one snooped bus event (remote read, remote invalidate or remote write). It looks up the addressed line and computes the new state. It then registers the bus actions that the transition requires: fetch the line, broadcast an invalidate, write back, or source the data for a remote reader. It also reports whether this cache holds a copy that a remote reader must see as shared.

The Owned state lets a dirty line be shared without a memory update. After a remote read of a Modified line, this cache stays responsible for the data and keeps supplying it to later readers. Memory stays stale until the line is evicted, and the eviction raises a write-back.

When a snooped event arrives, it wins the cycle. Any local event in that same cycle is dropped, and the processor side must retry it. Data storage, replacement choice and the interconnect are outside the block.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid and all action outputs are low. The state code is I=0, S=1, E=2, O=3, M=4.
- R2: A local read (loc_op=1) of a line in S, E, O or M raises o_hit, leaves the state unchanged and raises no bus action.
- R3: A local read of an Invalid line raises o_bus_read. The line fills to E when i_shared is low and to S when i_shared is high.
- R4: A local write (loc_op=2) always leaves the line in M. From E or M it raises no bus action. From S or O it raises o_inval. From I it raises both o_bus_read and o_inval.
- R5: A local evict (loc_op=3) leaves the line Invalid. It raises o_wback only when the line was in M or O.
- R6: A snooped read (snp_op=1) moves M to O and leaves O in O, both with o_supply. It moves E to S and leaves S in S without o_supply. Every valid line raises o_has_copy. An Invalid line does nothing.
- R7: A snooped invalidate (snp_op=2) or remote write (snp_op=3) leaves the line Invalid. It raises o_supply only when the line was in M or O.
- R8: When snp_op is non-zero, the local event of that cycle is ignored. It changes no line and raises none of o_hit, o_bus_read, o_inval or o_wback.
- R9: All outputs are registered and reflect the event of the previous cycle. o_state shows the new state of the addressed line: snp_idx when a snoop is present, otherwise loc_idx. With both ops at 0 it is a side-effect-free lookup of loc_idx.
- R10: An event changes only the line it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_op | input | 2 | Local event: 0 none, 1 read, 2 write, 3 evict |
| loc_idx | input | IDX_W | Line index of the local event |
| snp_op | input | 2 | Snooped event: 0 none, 1 read, 2 invalidate, 3 remote write |
| snp_idx | input | IDX_W | Line index of the snooped event |
| i_shared | input | 1 | Another cache reports a copy during a read miss |
| o_state | output | 3 | New state of the addressed line |
| o_hit | output | 1 | Local read hit |
| o_bus_read | output | 1 | Fetch the line over the bus |
| o_inval | output | 1 | Broadcast invalidate of other copies |
| o_wback | output | 1 | Write dirty line back to memory |
| o_supply | output | 1 | This cache must source the data for the snoop |
| o_has_copy | output | 1 | This cache holds a valid copy for a snooped read |

## Verification
The Owned state is the hardest to reach from the ports. It needs a line to be written first, through a write miss or a silent upgrade from Exclusive, and only then snooped by a read. After that, Owned has to be left through a local write (with invalidate), an eviction (with write-back) or a remote invalidate (with data supply). The directed sequences build each of these chains on separate lines. Same-cycle collisions of a snoop and a local event, on the same line and on different lines, are also forced. A long pseudo-random run over a few lines then mixes everything, with every cycle compared against a behavioural model.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } line_st_t;

  typedef enum logic [1:0] {
    LOP_NONE  = 2'd0,
    LOP_READ  = 2'd1,
    LOP_WRITE = 2'd2,
    LOP_EVICT = 2'd3
  } loc_op_t;

  typedef enum logic [1:0] {
    SNP_NONE  = 2'd0,
    SNP_READ  = 2'd1,
    SNP_INVAL = 2'd2,
    SNP_RWR   = 2'd3
  } snp_op_t;

  typedef struct packed {
    line_st_t nxt;
    logic     hit;
    logic     bus_read;
    logic     inval;
    logic     wback;
    logic     supply;
    logic     has_copy;
  } act_t;

endpackage

// File: rtl/moesi_state_array.sv
module moesi_state_array
  import moesi_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output line_st_t         rd_st,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  line_st_t         wr_st
);

  line_st_t mem [LINES];

  assign rd_st = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) mem[i] <= ST_I;
    end else if (we) begin
      mem[wr_idx] <= wr_st;
    end
  end

endmodule

// File: rtl/moesi_local_fsm.sv
module moesi_local_fsm
  import moesi_pkg::*;
(
  input  loc_op_t  op,
  input  line_st_t cur,
  input  logic     shared_in,
  output act_t     act
);

  always_comb begin
    act          = '0;
    act.nxt      = cur;
    unique case (op)
      LOP_READ: begin
        if (cur == ST_I) begin
          act.bus_read = 1'b1;
          act.nxt      = shared_in ? ST_S : ST_E;
        end else begin
          act.hit = 1'b1;
        end
      end
      LOP_WRITE: begin
        act.nxt = ST_M;
        unique case (cur)
          ST_I: begin
            act.bus_read = 1'b1;
            act.inval    = 1'b1;
          end
          ST_S, ST_O: act.inval = 1'b1;
          default: ;
        endcase
      end
      LOP_EVICT: begin
        act.nxt   = ST_I;
        act.wback = (cur == ST_M) || (cur == ST_O);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/moesi_snoop_fsm.sv
module moesi_snoop_fsm
  import moesi_pkg::*;
(
  input  snp_op_t  op,
  input  line_st_t cur,
  output act_t     act
);

  logic dirty;
  assign dirty = (cur == ST_M) || (cur == ST_O);

  always_comb begin
    act     = '0;
    act.nxt = cur;
    unique case (op)
      SNP_READ: begin
        act.has_copy = (cur != ST_I);
        act.supply   = dirty;
        unique case (cur)
          ST_M: act.nxt = ST_O;
          ST_E: act.nxt = ST_S;
          default: ;
        endcase
      end
      SNP_INVAL, SNP_RWR: begin
        act.nxt    = ST_I;
        act.supply = dirty;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
  import moesi_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       loc_op,
  input  logic [IDX_W-1:0] loc_idx,
  input  logic [1:0]       snp_op,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic             i_shared,
  output logic [2:0]       o_state,
  output logic             o_hit,
  output logic             o_bus_read,
  output logic             o_inval,
  output logic             o_wback,
  output logic             o_supply,
  output logic             o_has_copy
);

  logic             snp_act;
  logic [IDX_W-1:0] sel_idx;
  line_st_t         cur;
  act_t             loc_a, snp_a, sel_a;
  logic             we;

  assign snp_act = (snp_op != SNP_NONE);
  assign sel_idx = snp_act ? snp_idx : loc_idx;

  moesi_state_array #(.LINES(LINES)) u_array (
    .clk    (clk),
    .rst    (rst),
    .rd_idx (sel_idx),
    .rd_st  (cur),
    .we     (we),
    .wr_idx (sel_idx),
    .wr_st  (sel_a.nxt)
  );

  moesi_local_fsm u_local (
    .op        (loc_op_t'(loc_op)),
    .cur       (cur),
    .shared_in (i_shared),
    .act       (loc_a)
  );

  moesi_snoop_fsm u_snoop (
    .op  (snp_op_t'(snp_op)),
    .cur (cur),
    .act (snp_a)
  );

  assign sel_a = snp_act ? snp_a : loc_a;
  assign we    = (sel_a.nxt != cur);

  always_ff @(posedge clk) begin
    if (rst) begin
      o_state    <= ST_I;
      o_hit      <= 1'b0;
      o_bus_read <= 1'b0;
      o_inval    <= 1'b0;
      o_wback    <= 1'b0;
      o_supply   <= 1'b0;
      o_has_copy <= 1'b0;
    end else begin
      o_state    <= sel_a.nxt;
      o_hit      <= sel_a.hit;
      o_bus_read <= sel_a.bus_read;
      o_inval    <= sel_a.inval;
      o_wback    <= sel_a.wback;
      o_supply   <= sel_a.supply;
      o_has_copy <= sel_a.has_copy;
    end
  end

  AST_SUPPLY_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (rst)
    o_supply |-> ($past(!rst) && $past(snp_op) != 2'd0)); // R7

  AST_WBACK_NEEDS_EVICT: assert property (@(posedge clk) disable iff (rst)
    o_wback |-> ($past(loc_op) == 2'd3 && $past(snp_op) == 2'd0)); // R5

  AST_INVAL_CLEARS_LINE: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(snp_op[1])) |-> (o_state == 3'(ST_I))); // R7

  AST_FILL_BY_SHARED: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(loc_op) == 2'd1 && $past(snp_op) == 2'd0 && $past(cur) == ST_I)
      |-> (o_state == ($past(i_shared) ? 3'(ST_S) : 3'(ST_E)))); // R3

  AST_EXCL_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(loc_op) == 2'd2 && $past(snp_op) == 2'd0 && $past(cur) == ST_E)
      |-> (!o_inval && !o_bus_read && o_state == 3'(ST_M))); // R4

  AST_SNOOP_BLOCKS_LOCAL: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(snp_op) != 2'd0)
      |-> (!o_hit && !o_wback && !o_bus_read && !o_inval)); // R8

endmodule

// File: tb/sim_moesi_line_ctrl.sv
`timescale 1ns/1ps
module sim_moesi_line_ctrl;

  localparam int LINES = 16;
  localparam int IDX_W = $clog2(LINES);
  localparam int SI = 0, SS = 1, SE = 2, SO = 3, SM = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       loc_op = '0;
  logic [IDX_W-1:0] loc_idx = '0;
  logic [1:0]       snp_op = '0;
  logic [IDX_W-1:0] snp_idx = '0;
  logic             i_shared = 1'b0;
  logic [2:0]       o_state;
  logic             o_hit, o_bus_read, o_inval, o_wback, o_supply, o_has_copy;

  int checks = 0;
  int failures = 0;
  int mdl [LINES];
  bit done = 1'b0;

  always #5 clk = ~clk;

  moesi_line_ctrl #(.LINES(LINES)) u0 (
    .clk(clk), .rst(rst), .loc_op(loc_op), .loc_idx(loc_idx),
    .snp_op(snp_op), .snp_idx(snp_idx), .i_shared(i_shared),
    .o_state(o_state), .o_hit(o_hit), .o_bus_read(o_bus_read),
    .o_inval(o_inval), .o_wback(o_wback), .o_supply(o_supply),
    .o_has_copy(o_has_copy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // flags order: hit, bus_read, inval, wback, supply, has_copy
  task automatic step(input int lop, input int li, input int sop, input int si,
                      input int sh, input string req);
    int idx, cur, nxt;
    bit [5:0] ef, af;
    loc_op = 2'(lop); loc_idx = IDX_W'(li);
    snp_op = 2'(sop); snp_idx = IDX_W'(si); i_shared = sh[0];
    ef = '0;
    idx = (sop != 0) ? si : li;
    cur = mdl[idx];
    nxt = cur;
    if (sop == 1) begin
      if (cur != SI) ef[0] = 1;
      if (cur == SM || cur == SO) ef[1] = 1;
      if (cur == SM) nxt = SO;
      if (cur == SE) nxt = SS;
    end else if (sop >= 2) begin
      if (cur == SM || cur == SO) ef[1] = 1;
      nxt = SI;
    end else if (lop == 1) begin
      if (cur == SI) begin ef[4] = 1; nxt = sh ? SS : SE; end
      else ef[5] = 1;
    end else if (lop == 2) begin
      if (cur == SI) begin ef[4] = 1; ef[3] = 1; end
      if (cur == SS || cur == SO) ef[3] = 1;
      nxt = SM;
    end else if (lop == 3) begin
      if (cur == SM || cur == SO) ef[2] = 1;
      nxt = SI;
    end
    mdl[idx] = nxt;
    @(negedge clk);
    af = {o_hit, o_bus_read, o_inval, o_wback, o_supply, o_has_copy};
    check(o_state == 3'(nxt), {req, " state"}, int'(o_state), nxt);
    check(af == ef, {req, " actions"}, int'(af), int'(ef));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit [15:0] lf;
    for (int i = 0; i < LINES; i++) mdl[i] = SI;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, peek every line
    for (int i = 0; i < LINES; i++) step(0, i, 0, 0, 0, "R1");
    // line 1: E -> hit -> M silent -> O -> O -> M (inval) -> evict
    step(1, 1, 0, 0, 0, "R3");
    step(1, 1, 0, 0, 0, "R2");
    step(2, 1, 0, 0, 0, "R4");
    step(1, 1, 0, 0, 0, "R2");
    step(0, 0, 1, 1, 0, "R6");
    step(0, 0, 1, 1, 0, "R6");
    step(1, 1, 0, 0, 0, "R2");
    step(2, 1, 0, 0, 0, "R4");
    step(2, 1, 0, 0, 0, "R4");
    step(3, 1, 0, 0, 0, "R5");
    // line 2: S fill, write upgrade, remote invalidate of M
    step(1, 2, 0, 0, 1, "R3");
    step(2, 2, 0, 0, 0, "R4");
    step(0, 0, 2, 2, 0, "R7");
    // line 3: write miss, snoop read to O, evict O
    step(2, 3, 0, 0, 0, "R4");
    step(0, 0, 1, 3, 0, "R6");
    step(3, 3, 0, 0, 0, "R5");
    // line 4: E, snooped to S, evict S, snoop on I
    step(1, 4, 0, 0, 0, "R3");
    step(0, 0, 1, 4, 0, "R6");
    step(0, 0, 1, 4, 0, "R6");
    step(3, 4, 0, 0, 0, "R5");
    step(0, 0, 1, 4, 0, "R6");
    step(3, 4, 0, 0, 0, "R5");
    // line 5/6/7: remote write on E, invalidate on S, evict E, owned invalidate
    step(1, 5, 0, 0, 0, "R3");
    step(0, 0, 3, 5, 0, "R7");
    step(1, 6, 0, 0, 1, "R3");
    step(0, 0, 2, 6, 0, "R7");
    step(1, 7, 0, 0, 0, "R3");
    step(3, 7, 0, 0, 0, "R5");
    step(2, 7, 0, 0, 0, "R4");
    step(0, 0, 1, 7, 0, "R6");
    step(0, 0, 3, 7, 0, "R7");
    // R8: snoop wins, local dropped (different and same line)
    step(2, 8, 0, 0, 0, "R4");
    step(3, 8, 1, 9, 0, "R8");
    step(0, 8, 0, 0, 0, "R8");
    step(1, 10, 0, 0, 0, "R3");
    step(2, 10, 1, 10, 0, "R8");
    step(0, 10, 0, 0, 0, "R8");
    step(1, 11, 2, 11, 0, "R8");
    step(0, 11, 0, 0, 0, "R8");
    // R10: all lines still match the model
    for (int i = 0; i < LINES; i++) step(0, i, 0, 0, 0, "R10");
    // R9: pseudo-random mix over four lines
    lf = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(int'(lf[1:0]), int'(lf[3:2]) + 12,
           lf[9] ? int'(lf[5:4]) : 0, int'(lf[7:6]) + 12, int'(lf[8]), "R9");
    end
    for (int i = 0; i < LINES; i++) step(0, i, 0, 0, 0, "R10");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule